// File: doc/BRIEF.md
# Grouped Multi-Core Interrupt Router

This block gathers interrupt requests from a set of source groups and delivers them to up to four processor cores. Each group is a 32-bit word of sticky pending bits. Hardware lines, software writes, or a write to a set port can raise a bit. A 4-bit routing code per source picks the core that may see the request, or blocks it.

For every group the block forms one summary word per core. The summary shows which pending sources are routed to that core. A per-core hierarchy word then shows which groups hold anything pending for that core. Each core receives one level interrupt output, which is the registered OR of its hierarchy word.

Software reaches all state through a single-cycle 32-bit register port. Read data is combinational in the request cycle, and writes take effect at the next clock edge. Inter-processor interrupts are made by writing to the set port of a group.

Top module: `irq_router`

## Requirements
- R1: After a synchronous active-low reset, every status word and every target word reads zero and `irq_o` is all zero.
- R2: A high level on `irq_in[32*g + b]` sets bit b of group g's status word at the next edge. Bit b holds source 31-b, so source 0 is bit 31. The bit stays set after the line drops.
- R3: In group g's 0x80-byte window, byte offset 0x00 reads the status word, and a write there replaces it. A read at offset 0x04 returns the status word and clears it at the same edge.
- R4: A write to offset 0x08 clears the status bits that are one in the data. A write to offset 0x0C sets them. When a set (from the port or from `irq_in`) and a clear hit the same bit in one cycle, the bit ends up set.
- R5: The target words are read/write at offsets 0x10, 0x14, 0x18 and 0x1C. Source n uses the word at 0x10 + 4*(n/8), in bits [(7 - n%8)*4 + 3 : (7 - n%8)*4].
- R6: A target code whose bits 3:2 are 01 routes its source to the core numbered in bits 1:0. Any other code, zero included, routes it nowhere. A status bit stays readable whatever its code.
- R7: The read-only summary word for core c sits at offset 0x20 + 4*c. Bit b of that word is set exactly when status bit b is set and the code of source 31-b routes to core c.
- R8: The read-only hierarchy word for core c sits at byte address NUM_GROUPS*0x80 + 4*c. Its bit 31-g is the OR of core c's summary word in group g.
- R9: `irq_o[c]` equals the OR of core c's hierarchy word as it stood one clock earlier.
- R10: Reads return zero at these places: unused window offsets (0x30 and up), hierarchy words past the last core, and addresses beyond the hierarchy block. Writes to read-only places change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 32*NUM_GROUPS | Raw request lines; word g feeds group g |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Read data, valid during a read cycle, zero otherwise |
| irq_o | output | NUM_CORES | Registered per-core interrupt lines |

## Verification
The bench builds the router with three groups and four cores. This places the hierarchy block at 0x180 and narrows the address to nine bits. With that size, every source of every group can be swept against all sixteen routing codes. Each combination checks the target placement, the summary word of each core, the hierarchy bit, the status visibility and the core line. Directed cases cover the one-cycle output lag, the case where a set and a clear hit the same bit, clear-on-read, two groups pending for one core, and writes to read-only locations.

// File: rtl/irq_router_pkg.sv
// Shared constants and routing decode for the interrupt router.
// Assumes 32-bit words, 4-bit routing codes and a 0x80-byte group window.
package irq_router_pkg;
    localparam int WORD_W        = 32;
    localparam int NIB_W         = 4;
    localparam int NIBS_PER_WORD = WORD_W / NIB_W;
    localparam int TGT_WORDS     = WORD_W / NIBS_PER_WORD;
    localparam int WIN_BITS      = 7;
    localparam int WIDX_W        = WIN_BITS - 2;

    // word indexes inside a group window
    localparam logic [WIDX_W-1:0] WI_STATUS = 5'd0;
    localparam logic [WIDX_W-1:0] WI_RDCLR  = 5'd1;
    localparam logic [WIDX_W-1:0] WI_CLR    = 5'd2;
    localparam logic [WIDX_W-1:0] WI_SET    = 5'd3;
    localparam logic [WIDX_W-1:0] WI_TGT    = 5'd4;
    localparam logic [WIDX_W-1:0] WI_NSUM   = 5'd8;
    localparam logic [WIDX_W-1:0] WI_LIMIT  = 5'd12;

    localparam logic [1:0] KIND_NORMAL = 2'b01;

    // true when a routing code delivers normally to the given core
    function automatic logic routes_to(input logic [NIB_W-1:0] code,
                                       input logic [1:0] core);
        return (code[3:2] == KIND_NORMAL) && (code[1:0] == core);
    endfunction
endpackage

// File: rtl/irq_group_bank.sv
// One group: sticky status word, four routing words, per-core summaries.
// Assumes at most one register access per cycle, already decoded to this group.
module irq_group_bank
    import irq_router_pkg::*;
#(
    parameter int NUM_CORES = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [WORD_W-1:0]            src_in,
    input  logic                         acc_wr,
    input  logic                         acc_rd,
    input  logic [WIDX_W-1:0]            acc_idx,
    input  logic [WORD_W-1:0]            acc_wdata,
    output logic [WORD_W-1:0]            status_o,
    output logic [TGT_WORDS*WORD_W-1:0]  tgt_o,
    output logic [NUM_CORES*WORD_W-1:0]  summ_o
);
    logic [WORD_W-1:0] status_q, status_d;
    logic [WORD_W-1:0] base_w, clr_mask, set_mask;
    logic [WORD_W-1:0] tgt_q [TGT_WORDS];

    // next status: replace, then clear, then set (set dominates)
    always_comb begin
        base_w   = status_q;
        clr_mask = '0;
        set_mask = src_in;
        if (acc_wr) begin
            case (acc_idx)
                WI_STATUS: base_w   = acc_wdata;
                WI_CLR:    clr_mask = acc_wdata;
                WI_SET:    set_mask = src_in | acc_wdata;
                default:   ;
            endcase
        end
        if (acc_rd && acc_idx == WI_RDCLR) clr_mask = '1;
        status_d = (base_w & ~clr_mask) | set_mask;
    end

    // status register
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= status_d;
    end

    // routing words, written whole
    always_ff @(posedge clk) begin
        for (int t = 0; t < TGT_WORDS; t++) begin
            if (!rst_n)
                tgt_q[t] <= '0;
            else if (acc_wr && acc_idx == WI_TGT + WIDX_W'(t))
                tgt_q[t] <= acc_wdata;
        end
    end

    assign status_o = status_q;

    generate
        for (genvar t = 0; t < TGT_WORDS; t++) begin : g_tgt_out
            assign tgt_o[t*WORD_W +: WORD_W] = tgt_q[t];
        end
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
            for (genvar b = 0; b < WORD_W; b++) begin : g_bit
                localparam int SRC  = WORD_W - 1 - b;
                localparam int TW   = SRC / NIBS_PER_WORD;
                localparam int NLSB = (NIBS_PER_WORD - 1 - SRC % NIBS_PER_WORD) * NIB_W;
                assign summ_o[c*WORD_W + b] =
                    status_q[b] & routes_to(tgt_q[TW][NLSB +: NIB_W], 2'(c));
            end
        end
    endgenerate
endmodule

// File: rtl/irq_hier_merge.sv
// Folds per-group summaries into per-core hierarchy words and drives the
// registered core lines. Assumes NUM_GROUPS <= 32; group g maps to bit 31-g.
module irq_hier_merge
    import irq_router_pkg::*;
#(
    parameter int NUM_GROUPS = 15,
    parameter int NUM_CORES  = 4
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_GROUPS*NUM_CORES*WORD_W-1:0] summ_all,
    output logic [NUM_CORES*WORD_W-1:0]            hier_o,
    output logic [NUM_CORES-1:0]                   irq_o
);
    generate
        for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
            for (genvar b = 0; b < WORD_W; b++) begin : g_bit
                localparam int GRP = WORD_W - 1 - b;
                if (GRP < NUM_GROUPS) begin : g_live
                    assign hier_o[c*WORD_W + b] =
                        |summ_all[(GRP*NUM_CORES + c)*WORD_W +: WORD_W];
                end else begin : g_zero
                    assign hier_o[c*WORD_W + b] = 1'b0;
                end
            end
        end
    endgenerate

    // one register stage per core line
    always_ff @(posedge clk) begin
        for (int c = 0; c < NUM_CORES; c++) begin
            if (!rst_n) irq_o[c] <= 1'b0;
            else        irq_o[c] <= |hier_o[c*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/irq_reg_read.sv
// Combinational read multiplexer over group windows and the hierarchy block.
// Assumes the hierarchy block occupies the window right after the last group.
module irq_reg_read
    import irq_router_pkg::*;
#(
    parameter int NUM_GROUPS = 15,
    parameter int NUM_CORES  = 4,
    parameter int ADDR_W     = 11
) (
    input  logic                                   rd_en,
    input  logic [ADDR_W-1:0]                      rd_addr,
    input  logic [NUM_GROUPS*WORD_W-1:0]           status_all,
    input  logic [NUM_GROUPS*TGT_WORDS*WORD_W-1:0] tgt_all,
    input  logic [NUM_GROUPS*NUM_CORES*WORD_W-1:0] summ_all,
    input  logic [NUM_CORES*WORD_W-1:0]            hier_all,
    output logic [WORD_W-1:0]                      rd_data
);
    int gi, ix;
    logic unused_lsb;

    assign unused_lsb = ^rd_addr[1:0];

    // select the addressed word; everything unmapped reads zero
    always_comb begin
        gi      = int'(rd_addr[ADDR_W-1:WIN_BITS]);
        ix      = int'(rd_addr[WIN_BITS-1:2]);
        rd_data = '0;
        if (rd_en) begin
            if (gi < NUM_GROUPS) begin
                if (ix == int'(WI_STATUS) || ix == int'(WI_RDCLR))
                    rd_data = status_all[gi*WORD_W +: WORD_W];
                else if (ix >= int'(WI_TGT) && ix < int'(WI_TGT) + TGT_WORDS)
                    rd_data = tgt_all[(gi*TGT_WORDS + ix - int'(WI_TGT))*WORD_W +: WORD_W];
                else if (ix >= int'(WI_NSUM) && ix < int'(WI_NSUM) + NUM_CORES)
                    rd_data = summ_all[(gi*NUM_CORES + ix - int'(WI_NSUM))*WORD_W +: WORD_W];
            end else if (gi == NUM_GROUPS && ix < NUM_CORES) begin
                rd_data = hier_all[ix*WORD_W +: WORD_W];
            end
        end
    end
endmodule

// File: rtl/irq_router.sv
// Top of the interrupt router: decodes the register port, instantiates one
// bank per group, the hierarchy merge and the read multiplexer.
// Assumes NUM_CORES <= 4 and NUM_GROUPS <= 32.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_GROUPS = 15,
    parameter int NUM_CORES  = 4,
    parameter int ADDR_W     = $clog2((NUM_GROUPS + 1) * (1 << WIN_BITS))
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_GROUPS*WORD_W-1:0] irq_in,
    input  logic                         req_valid,
    input  logic                         req_write,
    input  logic [ADDR_W-1:0]            req_addr,
    input  logic [WORD_W-1:0]            req_wdata,
    output logic [WORD_W-1:0]            rsp_rdata,
    output logic [NUM_CORES-1:0]         irq_o
);
    localparam int GRP_W = ADDR_W - WIN_BITS;

    logic [GRP_W-1:0]                       acc_grp;
    logic [WIDX_W-1:0]                      acc_idx;
    logic                                   wr_any, rd_any;
    logic [NUM_GROUPS*WORD_W-1:0]           status_all;
    logic [NUM_GROUPS*TGT_WORDS*WORD_W-1:0] tgt_all;
    logic [NUM_GROUPS*NUM_CORES*WORD_W-1:0] summ_all;
    logic [NUM_CORES*WORD_W-1:0]            hier_all;

    // address split and access kind
    assign acc_grp = req_addr[ADDR_W-1:WIN_BITS];
    assign acc_idx = req_addr[WIN_BITS-1:2];
    assign wr_any  = req_valid & req_write;
    assign rd_any  = req_valid & ~req_write;

    generate
        for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
            irq_group_bank #(.NUM_CORES(NUM_CORES)) u_bank (
                .clk       (clk),
                .rst_n     (rst_n),
                .src_in    (irq_in[g*WORD_W +: WORD_W]),
                .acc_wr    (wr_any && acc_grp == GRP_W'(g)),
                .acc_rd    (rd_any && acc_grp == GRP_W'(g)),
                .acc_idx   (acc_idx),
                .acc_wdata (req_wdata),
                .status_o  (status_all[g*WORD_W +: WORD_W]),
                .tgt_o     (tgt_all[g*TGT_WORDS*WORD_W +: TGT_WORDS*WORD_W]),
                .summ_o    (summ_all[g*NUM_CORES*WORD_W +: NUM_CORES*WORD_W])
            );
        end
    endgenerate

    irq_hier_merge #(.NUM_GROUPS(NUM_GROUPS), .NUM_CORES(NUM_CORES)) u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .summ_all (summ_all),
        .hier_o   (hier_all),
        .irq_o    (irq_o)
    );

    irq_reg_read #(.NUM_GROUPS(NUM_GROUPS), .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_read (
        .rd_en      (rd_any),
        .rd_addr    (req_addr),
        .status_all (status_all),
        .tgt_all    (tgt_all),
        .summ_all   (summ_all),
        .hier_all   (hier_all),
        .rd_data    (rsp_rdata)
    );
endmodule

// File: rtl/irq_router_chk.sv
// Property checker for the interrupt router, bound to the top module.
// Watches the register port, the status words and the hierarchy words.
module irq_router_chk
    import irq_router_pkg::*;
#(
    parameter int NG = 15,
    parameter int NC = 4,
    parameter int AW = 11
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NG*WORD_W-1:0] irq_in,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [AW-1:0]        req_addr,
    input logic [WORD_W-1:0]    req_wdata,
    input logic [WORD_W-1:0]    rsp_rdata,
    input logic [NC-1:0]        irq_o,
    input logic [NG*WORD_W-1:0] status_all,
    input logic [NC*WORD_W-1:0] hier_all
);
    logic [AW-WIN_BITS-1:0] grp, prev_grp;
    logic [WIDX_W-1:0]      idx;
    logic                   in_grp, in_hier;
    logic [WORD_W-1:0]      grp_irq, watch_status;
    logic [NC-1:0]          hier_any;

    assign grp     = req_addr[AW-1:WIN_BITS];
    assign idx     = req_addr[WIN_BITS-1:2];
    assign in_grp  = int'(grp) < NG;
    assign in_hier = int'(grp) == NG;
    assign grp_irq = in_grp ? irq_in[int'(grp)*WORD_W +: WORD_W] : '0;
    assign watch_status = (int'(prev_grp) < NG) ? status_all[int'(prev_grp)*WORD_W +: WORD_W] : '0;

    // remember the group accessed in the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) prev_grp <= '0;
        else        prev_grp <= grp;
    end

    // per-core OR of the hierarchy words
    always_comb begin
        for (int c = 0; c < NC; c++) hier_any[c] = |hier_all[c*WORD_W +: WORD_W];
    end

    // R1
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> irq_o == '0);

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (status_all & $past(irq_in)) == $past(irq_in));

    // R3
    rdclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && in_grp && idx == WI_RDCLR) |=> watch_status == $past(grp_irq));

    // R4
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && in_grp && idx == WI_SET)
        |=> (watch_status & $past(req_wdata)) == $past(req_wdata));

    // R9
    irq_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> irq_o == $past(hier_any));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write &&
         ((in_grp && idx >= WI_LIMIT) || (in_hier && int'(idx) >= NC) || (!in_grp && !in_hier)))
        |-> rsp_rdata == '0);
endmodule

bind irq_router irq_router_chk #(.NG(NUM_GROUPS), .NC(NUM_CORES), .AW(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_in     (irq_in),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .rsp_rdata  (rsp_rdata),
    .irq_o      (irq_o),
    .status_all (status_all),
    .hier_all   (hier_all)
);

// File: tb/test_irq_router.sv
// Self-checking bench: three groups, four cores, full source/code sweep.
module test_irq_router;
    localparam int CLK_PERIOD = 10;
    localparam int NG = 3;
    localparam int NC = 4;
    localparam int AW = $clog2((NG + 1) * 128);
    localparam int HIER_BASE = NG * 128;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NG*32-1:0]  irq_in = '0;
    logic              req_valid = 1'b0;
    logic              req_write = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [31:0]       rsp_rdata;
    logic [NC-1:0]     irq_o;

    int n_chk = 0;
    int n_fail = 0;

    irq_router #(.NUM_GROUPS(NG), .NUM_CORES(NC)) i_irq_router (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_rdata(rsp_rdata), .irq_o(irq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ga(input int g, input int off);
        return g * 128 + off;
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
        #1 d = rsp_rdata;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(tag, d, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        check("R1 irq_o after reset", 32'(irq_o), 32'h0);
        for (int g = 0; g < NG; g++) begin
            rd_chk("R1 status reset", ga(g, 'h00), 32'h0);
            for (int t = 0; t < 4; t++) rd_chk("R1 target reset", ga(g, 'h10 + 4*t), 32'h0);
        end

        // R10 unmapped reads
        rd_chk("R10 critical word", ga(0, 'h30), 32'h0);
        rd_chk("R10 mcheck word", ga(1, 'h40), 32'h0);
        rd_chk("R10 pad word", ga(2, 'h7C), 32'h0);
        rd_chk("R10 hier critical", HIER_BASE + 'h10, 32'h0);
        rd_chk("R10 hier mcheck", HIER_BASE + 'h24, 32'h0);

        // R3 status write, readback, clear-on-read
        wr(ga(1, 'h00), 32'hA5A5_0F0F);
        rd_chk("R3 status readback", ga(1, 'h00), 32'hA5A5_0F0F);
        rd_chk("R3 clear-on-read value", ga(1, 'h04), 32'hA5A5_0F0F);
        rd_chk("R3 cleared after read", ga(1, 'h00), 32'h0);

        // R4 set and clear ports, set wins
        wr(ga(2, 'h0C), 32'h0000_00F0);
        wr(ga(2, 'h08), 32'h0000_0030);
        rd_chk("R4 set then clear", ga(2, 'h00), 32'h0000_00C0);
        @(negedge clk);
        irq_in[2*32 + 7] = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(ga(2, 'h08)); req_wdata = 32'h0000_00C0;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0; irq_in = '0;
        rd_chk("R4 set beats clear", ga(2, 'h00), 32'h0000_0080);
        wr(ga(2, 'h08), 32'hFFFF_FFFF);
        rd_chk("R4 clear all", ga(2, 'h00), 32'h0);

        // R2 pulse capture, sticky, source 0 is bit 31
        @(negedge clk);
        irq_in[0*32 + 31] = 1'b1;
        @(negedge clk);
        irq_in = '0;
        repeat (3) @(posedge clk);
        rd_chk("R2 sticky capture", ga(0, 'h00), 32'h8000_0000);
        wr(ga(0, 'h08), 32'h8000_0000);

        // R9 one-cycle lag of the core line
        wr(ga(0, 'h10), 32'h5000_0000);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(ga(0, 'h0C)); req_wdata = 32'h8000_0000;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
        check("R9 line not yet up", 32'(irq_o), 32'h0);
        @(posedge clk); #1;
        check("R9 line up one cycle later", 32'(irq_o), 32'h2);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(ga(0, 'h08)); req_wdata = 32'h8000_0000;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0;
        check("R9 line still up", 32'(irq_o), 32'h2);
        @(posedge clk); #1;
        check("R9 line down", 32'(irq_o), 32'h0);
        wr(ga(0, 'h10), 32'h0);

        // R8 two groups pending for core 3
        wr(ga(0, 'h10), 32'h7000_0000);
        wr(ga(2, 'h1C), 32'h0000_0007);
        wr(ga(0, 'h0C), 32'h8000_0000);
        wr(ga(2, 'h0C), 32'h0000_0001);
        rd_chk("R8 core3 two groups", HIER_BASE + 12, 32'hA000_0000);
        rd_chk("R8 core0 idle", HIER_BASE + 0, 32'h0);
        check("R9 core3 line", 32'(irq_o), 32'h8);
        wr(ga(0, 'h08), 32'hFFFF_FFFF);
        wr(ga(2, 'h08), 32'hFFFF_FFFF);
        wr(ga(0, 'h10), 32'h0);
        wr(ga(2, 'h1C), 32'h0);

        // R10 writes to read-only places are ignored
        wr(ga(0, 'h0C), 32'h0000_0001);
        wr(ga(0, 'h20), 32'hFFFF_FFFF);
        wr(ga(0, 'h30), 32'hFFFF_FFFF);
        wr(HIER_BASE + 0, 32'hFFFF_FFFF);
        rd_chk("R10 summary unchanged", ga(0, 'h20), 32'h0);
        rd_chk("R10 hier unchanged", HIER_BASE + 0, 32'h0);
        rd_chk("R10 status unchanged", ga(0, 'h00), 32'h0000_0001);
        rd_chk("R10 target unchanged", ga(0, 'h10), 32'h0);
        wr(ga(0, 'h08), 32'hFFFF_FFFF);

        // R5 R6 R7 R8 R9 sweep of every source against every code
        for (int g = 0; g < NG; g++) begin
            for (int n = 0; n < 32; n++) begin
                for (int code = 0; code < 16; code++) begin
                    int taddr;
                    logic [31:0] tword, sbit;
                    logic [3:0] exp_irq;
                    taddr = ga(g, 'h10 + 4*(n/8));
                    tword = 32'(code) << ((7 - n%8) * 4);
                    sbit  = 32'h1 << (31 - n);
                    exp_irq = '0;
                    wr(taddr, tword);
                    rd_chk("R5 target placement", taddr, tword);
                    wr(ga(g, 'h0C), sbit);
                    rd_chk("R6 status visible", ga(g, 'h00), sbit);
                    for (int c = 0; c < NC; c++) begin
                        logic hit;
                        hit = (code[3:2] == 2'b01) && (code[1:0] == c[1:0]);
                        exp_irq[c] = hit;
                        rd_chk("R7 summary word", ga(g, 'h20 + 4*c), hit ? sbit : 32'h0);
                        rd_chk("R8 hierarchy word", HIER_BASE + 4*c, hit ? (32'h1 << (31 - g)) : 32'h0);
                    end
                    check("R9 core lines", 32'(irq_o), 32'(exp_irq));
                    wr(ga(g, 'h08), sbit);
                    wr(taddr, 32'h0);
                end
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule